// File: doc/BRIEF.md
# Forward-Edge Landing Pad Checker

This block sits beside the retire stage of a RISC-V style core and enforces forward-edge control-flow integrity. It watches each retired instruction. When a register-indirect jump retires whose source register is not one of the exempt ones, the block arms a one-instruction expectation. The next retired instruction must then be a landing pad hint placed on a 4-byte boundary. If the pad carries a nonzero 20-bit label, that label must also equal the label held in register x7.

If any of these rules is broken, the block raises a software-check exception request in the same cycle as the offending instruction. The request carries the exception cause and the trap value. The expectation flag is visible to the rest of the core so it can be saved across context switches. An enable bit turns the whole check off. A trap-taken input tells the block that the instruction flow was redirected by an asynchronous trap.

Top module: `lpad_cfi_checker`

## Requirements
- R1: With `en` high, a retiring instruction with opcode bits [6:0] = 1100111 and funct3 bits [14:12] = 000 (an indirect jump), whose source register in bits [19:15] is not exempt, sets `lp_armed` from the next cycle. The same opcode with any other funct3 leaves the flag low.
- R2: Indirect jumps whose source register is x1 or x5 are function returns and leave `lp_armed` low.
- R3: Indirect jumps whose source register is x7 are software-guarded far jumps and leave `lp_armed` low.
- R4: While `lp_armed` is high, if the next retiring instruction is not a landing pad, `exc_req` is high in that same cycle. A landing pad is opcode 0010111 with destination bits [11:7] = 0. While `exc_req` is high, `exc_cause` = 18 and `exc_tval` = 2; otherwise both are 0.
- R5: While armed, a landing pad whose PC has bits [1:0] not equal to zero raises the exception.
- R6: While armed, an aligned landing pad with immediate bits [31:12] equal to zero is accepted whatever x7 holds.
- R7: While armed, an aligned landing pad with a nonzero immediate is accepted only if the immediate equals bits [31:12] of `label_reg`; otherwise the exception is raised.
- R8: A landing pad that retires while the flag is low behaves as a no-op and raises no exception.
- R9: While `en` is low, `lp_armed` is low from the next cycle and `exc_req` stays low.
- R10: `lp_armed` holds through cycles with no retiring instruction. It clears after the next retiring instruction, whether that instruction passed or failed. That instruction does not re-arm the flag, even if it is itself a tracked jump. `exc_req` lasts only the one cycle of the offending instruction.
- R11: In a cycle with `trap_taken` high, no exception is raised and `lp_armed` is low afterwards. This holds even if a tracked jump retires in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Landing pad enforcement enable |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | XLEN | Address of the retiring instruction |
| ret_insn | input | 32 | Encoding of the retiring instruction |
| label_reg | input | XLEN | Current value of x7 |
| trap_taken | input | 1 | Asynchronous trap redirects flow this cycle |
| exc_req | output | 1 | Software-check exception request |
| exc_cause | output | CAUSE_W | Exception cause (18 when requested) |
| exc_tval | output | XLEN | Trap value (2 when requested) |
| lp_armed | output | 1 | Landing pad expectation is pending |

## Verification
Two functions of the block can fall in the same cycle: the check that consumes a pending expectation, and the decode that would arm a new one. To provoke this, the bench retires a tracked indirect jump as the very instruction that follows an armed jump. The design is judged correct if `exc_req` rises for that one cycle and `lp_armed` is low afterwards, rather than re-armed. A second collision puts `trap_taken` in the same cycle as a tracked jump. Here the trap must win: the flag stays low and no exception is raised.

// File: rtl/lpad_cfi_pkg.sv
package lpad_cfi_pkg;
  localparam int INSN_W  = 32;
  localparam int LABEL_W = 20;
  localparam int LABEL_LO = 12;
  localparam int LABEL_HI = LABEL_LO + LABEL_W - 1;

  localparam logic [6:0] OPC_JUMP_REG = 7'b1100111;
  localparam logic [6:0] OPC_UPPER_PC = 7'b0010111;
  localparam logic [2:0] F3_JUMP_REG  = 3'b000;

  // source registers that bypass the landing pad rule
  localparam int N_EXEMPT = 3;
  localparam logic [4:0] EXEMPT_SRC [N_EXEMPT] = '{5'd1, 5'd5, 5'd7};

  typedef struct packed {
    logic               tracked_jump;
    logic               is_pad;
    logic [LABEL_W-1:0] pad_label;
  } insn_info_t;
endpackage

// File: rtl/lpad_decode.sv
module lpad_decode
  import lpad_cfi_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output insn_info_t        info
);
  logic [6:0] opcode;
  logic [4:0] rd_f;
  logic [2:0] f3;
  logic [4:0] rs1_f;
  logic [N_EXEMPT-1:0] exempt_hit;

  assign opcode = insn[6:0];
  assign rd_f   = insn[11:7];
  assign f3     = insn[14:12];
  assign rs1_f  = insn[19:15];

  genvar g;
  generate
    for (g = 0; g < N_EXEMPT; g++) begin : g_exempt
      assign exempt_hit[g] = (rs1_f == EXEMPT_SRC[g]);
    end
  endgenerate

  always_comb begin
    info.tracked_jump = (opcode == OPC_JUMP_REG) && (f3 == F3_JUMP_REG)
                        && (exempt_hit == '0);
    info.is_pad       = (opcode == OPC_UPPER_PC) && (rd_f == 5'd0);
    info.pad_label    = insn[LABEL_HI:LABEL_LO];
  end
endmodule

// File: rtl/lpad_verdict.sv
module lpad_verdict
  import lpad_cfi_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int ALIGN_BITS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  insn_info_t      info,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] label_reg,
  output logic            violation
);
  logic misaligned;
  logic label_bad;
  logic unused_bits;

  assign misaligned  = |pc[ALIGN_BITS-1:0];
  assign label_bad   = (info.pad_label != '0) &&
                       (info.pad_label != label_reg[LABEL_HI:LABEL_LO]);
  assign unused_bits = ^{pc[XLEN-1:ALIGN_BITS], label_reg[XLEN-1:LABEL_HI+1],
                         label_reg[LABEL_LO-1:0]};

  always_comb begin
    if (!info.is_pad) violation = 1'b1;
    else              violation = misaligned | label_bad;
  end

  AST_ZERO_LABEL_PASSES: assert property (@(posedge clk) disable iff (rst)
    (info.is_pad && pc[ALIGN_BITS-1:0] == '0 && info.pad_label == '0) |-> !violation); // R6
  AST_ODD_PAD_FAILS: assert property (@(posedge clk) disable iff (rst)
    (info.is_pad && pc[ALIGN_BITS-1:0] != '0) |-> violation); // R5
endmodule

// File: rtl/lpad_expect_fsm.sv
module lpad_expect_fsm (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ret_valid,
  input  logic trap_taken,
  input  logic tracked_jump,
  output logic armed
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst || !en || trap_taken) armed_q <= 1'b0;
    else if (ret_valid)           armed_q <= armed_q ? 1'b0 : tracked_jump;
  end

  assign armed = armed_q;

  AST_JUMP_ARMS: assert property (@(posedge clk) disable iff (rst)
    (en && ret_valid && !armed && tracked_jump && !trap_taken) |=> armed); // R1
  AST_DISABLED_DISARMS: assert property (@(posedge clk) disable iff (rst)
    !en |=> !armed); // R9
  AST_CONSUMED_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (armed && ret_valid) |=> !armed); // R10
  AST_BUBBLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (armed && !ret_valid && en && !trap_taken) |=> armed); // R10
  AST_TRAP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    trap_taken |=> !armed); // R11
endmodule

// File: rtl/lpad_cfi_checker.sv
module lpad_cfi_checker
  import lpad_cfi_pkg::*;
#(
  parameter int XLEN        = 64,
  parameter int CAUSE_W     = 8,
  parameter int ALIGN_BITS  = 2,
  parameter int SWCHK_CAUSE = 18,
  parameter int LP_TVAL     = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               ret_valid,
  input  logic [XLEN-1:0]    ret_pc,
  input  logic [INSN_W-1:0]  ret_insn,
  input  logic [XLEN-1:0]    label_reg,
  input  logic               trap_taken,
  output logic               exc_req,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [XLEN-1:0]    exc_tval,
  output logic               lp_armed
);
  localparam logic [CAUSE_W-1:0] CAUSE_VAL = CAUSE_W'(SWCHK_CAUSE);
  localparam logic [XLEN-1:0]    TVAL_VAL  = XLEN'(LP_TVAL);

  insn_info_t info;
  logic       violation;
  logic       armed;

  lpad_decode u_decode (
    .insn (ret_insn),
    .info (info)
  );

  lpad_verdict #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_verdict (
    .clk       (clk),
    .rst       (rst),
    .info      (info),
    .pc        (ret_pc),
    .label_reg (label_reg),
    .violation (violation)
  );

  lpad_expect_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .ret_valid    (ret_valid),
    .trap_taken   (trap_taken),
    .tracked_jump (info.tracked_jump),
    .armed        (armed)
  );

  always_comb begin
    exc_req   = en && ret_valid && armed && !trap_taken && violation;
    exc_cause = exc_req ? CAUSE_VAL : '0;
    exc_tval  = exc_req ? TVAL_VAL  : '0;
  end

  assign lp_armed = armed;

  AST_EXC_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (armed && ret_valid && en && !trap_taken)); // R4
  AST_EXC_CODES: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (exc_cause == CAUSE_VAL && exc_tval == TVAL_VAL)); // R4
  AST_UNARMED_SILENT: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !exc_req); // R8
  AST_EXC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> !exc_req); // R10
endmodule

// File: tb/tb_lpad_cfi_checker.sv
module tb_lpad_cfi_checker;
  localparam int XLEN = 64;
  localparam int CW   = 8;

  logic            clk = 1'b0;
  logic            rst, en, ret_valid, trap_taken;
  logic [XLEN-1:0] ret_pc, label_reg;
  logic [31:0]     ret_insn;
  logic            exc_req, lp_armed;
  logic [CW-1:0]   exc_cause;
  logic [XLEN-1:0] exc_tval;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic            s_exc, s_armed;
  logic [CW-1:0]   s_cause;
  logic [XLEN-1:0] s_tval;

  always #4 clk = ~clk;

  lpad_cfi_checker #(.XLEN(XLEN), .CAUSE_W(CW)) dut (
    .clk(clk), .rst(rst), .en(en), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_insn(ret_insn), .label_reg(label_reg), .trap_taken(trap_taken),
    .exc_req(exc_req), .exc_cause(exc_cause), .exc_tval(exc_tval),
    .lp_armed(lp_armed)
  );

  function automatic logic [31:0] jr(input int rs, input logic [2:0] f3 = 3'b000);
    return {12'h000, 5'(rs), f3, 5'd0, 7'b1100111};
  endfunction
  function automatic logic [31:0] pad(input logic [19:0] lbl, input int rd = 0);
    return {lbl, 5'(rd), 7'b0010111};
  endfunction
  localparam logic [31:0] NOP = 32'h0000_0013;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive, sample combinational exception, then registered flag
  task automatic step(input bit v, input logic [XLEN-1:0] pc,
                      input logic [31:0] insn, input bit trap = 0);
    @(negedge clk);
    ret_valid = v; ret_pc = pc; ret_insn = insn; trap_taken = trap;
    #1;
    s_exc = exc_req; s_cause = exc_cause; s_tval = exc_tval;
    @(posedge clk); #1;
    ret_valid = 0; trap_taken = 0;
    s_armed = lp_armed;
  endtask

  task automatic expect_exc(input bit e, input string req, input string what);
    check(s_exc == e, req, {what, " exc_req"}, s_exc, e);
    check(s_cause == (e ? CW'(18) : CW'(0)), req, {what, " cause"}, s_cause, e ? 18 : 0);
    check(s_tval == (e ? XLEN'(2) : XLEN'(0)), req, {what, " tval"}, s_tval, e ? 2 : 0);
  endtask

  task automatic t_reset;
    rst = 1; en = 1; ret_valid = 0; trap_taken = 0; ret_pc = '0; ret_insn = NOP;
    label_reg = '0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check(lp_armed == 0, "R10", "reset armed", lp_armed, 0);
    check(exc_req == 0, "R4", "reset exc", exc_req, 0);
  endtask

  task automatic t_arm_good_pad;
    step(1, 64'h1000, jr(6));
    check(s_armed == 1, "R1", "jalr x6 arms", s_armed, 1);
    step(0, 64'h0, NOP);
    check(s_armed == 1, "R10", "bubble holds", s_armed, 1);
    label_reg = 64'hFFFF_FFFF;
    step(1, 64'h2000, pad(20'h0));
    expect_exc(0, "R6", "zero label pad");
    check(s_armed == 0, "R10", "pad consumes", s_armed, 0);
    step(1, 64'h1004, jr(6, 3'b001));
    check(s_armed == 0, "R1", "funct3 1 not tracked", s_armed, 0);
  endtask

  task automatic t_exempt;
    step(1, 64'h1000, jr(1));
    check(s_armed == 0, "R2", "x1 exempt", s_armed, 0);
    step(1, 64'h1000, jr(5));
    check(s_armed == 0, "R2", "x5 exempt", s_armed, 0);
    step(1, 64'h1000, jr(7));
    check(s_armed == 0, "R3", "x7 exempt", s_armed, 0);
    step(1, 64'h2000, NOP);
    expect_exc(0, "R3", "after exempt");
  endtask

  task automatic t_missing_pad;
    step(1, 64'h1000, jr(10));
    step(1, 64'h2000, NOP);
    expect_exc(1, "R4", "missing pad");
    check(s_armed == 0, "R10", "clear after exc", s_armed, 0);
    step(1, 64'h2004, NOP);
    expect_exc(0, "R10", "exc one cycle");
    step(1, 64'h1000, jr(10));
    step(1, 64'h2000, pad(20'h0, 5));
    expect_exc(1, "R4", "auipc rd=x5 not pad");
  endtask

  task automatic t_misaligned;
    step(1, 64'h1000, jr(11));
    step(1, 64'h2002, pad(20'h0));
    expect_exc(1, "R5", "pad at pc+2");
  endtask

  task automatic t_label;
    label_reg = 64'hABCD_0000_1234_5678;
    step(1, 64'h1000, jr(12));
    step(1, 64'h2000, pad(20'h12345));
    expect_exc(0, "R7", "label match");
    step(1, 64'h1000, jr(12));
    step(1, 64'h2000, pad(20'h12346));
    expect_exc(1, "R7", "label mismatch");
  endtask

  task automatic t_pad_unarmed;
    label_reg = '0;
    step(1, 64'h2002, pad(20'hABCDE));
    expect_exc(0, "R8", "pad unarmed");
    check(s_armed == 0, "R8", "pad unarmed flag", s_armed, 0);
  endtask

  task automatic t_disabled;
    en = 0;
    step(1, 64'h1000, jr(6));
    check(s_armed == 0, "R9", "disabled no arm", s_armed, 0);
    step(1, 64'h2000, NOP);
    expect_exc(0, "R9", "disabled no exc");
    en = 1;
    step(1, 64'h1000, jr(6));
    en = 0;
    step(0, 64'h0, NOP);
    check(s_armed == 0, "R9", "disable drops flag", s_armed, 0);
    en = 1;
  endtask

  task automatic t_trap;
    step(1, 64'h1000, jr(6));
    step(0, 64'h0, NOP, 1);
    check(s_armed == 0, "R11", "trap clears", s_armed, 0);
    step(1, 64'h2000, NOP);
    expect_exc(0, "R11", "no exc after trap");
    step(1, 64'h1000, jr(6), 1);
    check(s_armed == 0, "R11", "trap beats arming", s_armed, 0);
  endtask

  task automatic t_collision;
    step(1, 64'h1000, jr(6));
    step(1, 64'h2000, jr(9));
    expect_exc(1, "R10", "jump as landing instr");
    check(s_armed == 0, "R10", "no re-arm", s_armed, 0);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_arm_good_pad();
    t_exempt();
    t_missing_pad();
    t_misaligned();
    t_label();
    t_pad_unarmed();
    t_disabled();
    t_trap();
    t_collision();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule